// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home node for a fixed set of cached memory blocks shared by a parameterised number of processors. For every block it keeps one presence bit per processor and one dirty bit. It also holds a small backing memory. Processors send read or write (ownership) requests that carry the requester's index. The controller takes one request at a time and is the single point where all requests to a block are ordered.

A read of a clean block is answered from memory. A read of a dirty block first recalls the data from the owning cache, which downgrades to shared. The recalled data is written back to memory and then forwarded. A write gives the requester sole ownership. If the block is clean, every recorded sharer other than the requester is sent an invalidation, and the exclusive reply waits until all their acknowledgements have arrived. If the block is dirty, the current owner is recalled and invalidated, and its data is forwarded. While a request is in flight, the request port applies back-pressure.

Top module: `home_directory`

## Requirements
- R1: After reset, every presence vector and dirty bit is clear, block b of the backing memory holds MEM_BASE + b (default 0xA000 + b), `reqReady` is high, and `snpValid` and `rspValid` are low.
- R2: A request is accepted in a cycle where `reqValid` and `reqReady` are both high. For a read of a clean block, no snoop is issued and `rspValid` rises two cycles after acceptance. The reply carries the memory data, `rspExcl` = 0 and the requester's index, and the requester is added to the sharers.
- R3: A read of a dirty block owned by another processor issues a one-cycle snoop with `snpKind` = 1 (recall, keep shared copy), addressed only to the owner. The reply follows the cycle after `fillValid` and carries `fillData`. Memory is updated with that data, the dirty bit is cleared, and both the owner and the requester are recorded as sharers.
- R4: A write to a clean block whose sharer set holds processors other than the requester issues a one-cycle snoop with `snpKind` = 0 (invalidate). Its target vector is exactly the recorded sharers with the requester's bit cleared. Nothing outside that set is targeted.
- R5: The exclusive reply to a write that sent invalidations is withheld until every targeted cache has acknowledged on `ackVec`, whether the acks arrive on one cycle or on separate cycles. `rspValid` rises the cycle after the last acknowledgement.
- R6: A write to a clean block with no other sharers issues no snoop. It replies two cycles after acceptance with memory data and `rspExcl` = 1.
- R7: A write to a block that is dirty in another cache issues a snoop with `snpKind` = 2 (recall and invalidate) to the owner only. It replies with `fillData` the cycle after `fillValid` and writes that data to memory. The block stays dirty.
- R8: After any write completes, the requester is the only recorded holder and the block is dirty. Later requests snoop only that processor.
- R9: From acceptance until the reply cycle, `reqReady` is low, and requests presented on the port have no effect on any block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request will be taken |
| reqWrite | input | 1 | 1 = write (ownership), 0 = read |
| reqProc | input | PROC_W | Requesting processor index |
| reqAddr | input | ADDR_W | Block index |
| snpValid | output | 1 | One-cycle snoop message to caches |
| snpKind | output | 2 | 0 invalidate, 1 recall keep shared, 2 recall and invalidate |
| snpTargets | output | NUM_PROC | One bit per cache addressed by the snoop |
| snpAddr | output | ADDR_W | Block the snoop refers to |
| ackVec | input | NUM_PROC | Invalidation acknowledgement, one bit per cache |
| fillValid | input | 1 | Recalled data from the owner is present |
| fillData | input | DATA_W | Recalled data |
| rspValid | output | 1 | One-cycle reply to the requester |
| rspProc | output | PROC_W | Processor the reply is for |
| rspData | output | DATA_W | Reply data |
| rspExcl | output | 1 | Reply grants ownership |

## Verification
The hardest states to reach are a dirty line whose owner got ownership through an earlier write, and a write that must collect several acknowledgements while a competing request sits on the port. The stimulus builds a three-way sharer set from clean reads. It then writes from a fourth processor with staggered acknowledgements, and holds a conflicting write on the port for the whole busy period. It then moves ownership between processors through recall and invalidation. A read of an untouched block afterwards shows that the conflicting request had no effect.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WAIT_ACK,
    ST_WAIT_FILL,
    ST_REPLY
  } dirState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic loadMem;
    logic issueSnoop;
    logic takeAck;
    logic takeFill;
    logic commit;
  } dirStrobe_t;

  localparam logic [1:0] SNP_INVALIDATE = 2'd0;
  localparam logic [1:0] SNP_DOWNGRADE  = 2'd1;
  localparam logic [1:0] SNP_RECALL_INV = 2'd2;

endpackage

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       fillValid,
  input  logic       isWrite,
  input  logic       isDirty,
  input  logic       haveTargets,
  input  logic       acksDone,
  output logic       reqReady,
  output dirStrobe_t strobe
);

  dirState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    reqReady  = (state == ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.accept = 1'b1;
          nextState     = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (isDirty && haveTargets) begin
          strobe.issueSnoop = 1'b1;
          nextState         = ST_WAIT_FILL;
        end else if (isWrite && haveTargets) begin
          strobe.issueSnoop = 1'b1;
          nextState         = ST_WAIT_ACK;
        end else begin
          strobe.loadMem = 1'b1;
          nextState      = ST_REPLY;
        end
      end
      ST_WAIT_ACK: begin
        strobe.takeAck = 1'b1;
        if (acksDone) nextState = ST_REPLY;
      end
      ST_WAIT_FILL: begin
        if (fillValid) begin
          strobe.takeFill = 1'b1;
          nextState       = ST_REPLY;
        end
      end
      ST_REPLY: begin
        strobe.commit = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NUM_PROC   = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  parameter logic [DATA_W-1:0] MEM_BASE = 'hA000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dirStrobe_t                    strobe,
  input  logic                          reqWrite,
  input  logic [$clog2(NUM_PROC)-1:0]   reqProc,
  input  logic [$clog2(NUM_BLOCKS)-1:0] reqAddr,
  input  logic [NUM_PROC-1:0]           ackVec,
  input  logic [DATA_W-1:0]             fillData,
  output logic                          isWrite,
  output logic                          isDirty,
  output logic                          haveTargets,
  output logic                          acksDone,
  output logic [1:0]                    snpKind,
  output logic [NUM_PROC-1:0]           snpTargets,
  output logic [$clog2(NUM_BLOCKS)-1:0] snpAddr,
  output logic [$clog2(NUM_PROC)-1:0]   rspProc,
  output logic [DATA_W-1:0]             rspData,
  output logic                          rspExcl
);

  localparam int PROC_W = $clog2(NUM_PROC);
  localparam int ADDR_W = $clog2(NUM_BLOCKS);

  logic [NUM_PROC-1:0] presence [NUM_BLOCKS];
  logic                dirty    [NUM_BLOCKS];
  logic [DATA_W-1:0]   mem      [NUM_BLOCKS];

  logic                curWrite;
  logic [PROC_W-1:0]   curProc;
  logic [ADDR_W-1:0]   curAddr;
  logic [NUM_PROC-1:0] pending;
  logic [DATA_W-1:0]   dataReg;

  logic [NUM_PROC-1:0] reqBit;
  logic [NUM_PROC-1:0] targets;

  always_comb begin
    reqBit      = NUM_PROC'(1) << curProc;
    targets     = presence[curAddr] & ~reqBit;
    haveTargets = |targets;
    isDirty     = dirty[curAddr];
    isWrite     = curWrite;
    acksDone    = (pending & ~ackVec) == '0;
    if (!isDirty)      snpKind = SNP_INVALIDATE;
    else if (curWrite) snpKind = SNP_RECALL_INV;
    else               snpKind = SNP_DOWNGRADE;
    snpTargets  = strobe.issueSnoop ? targets : '0;
    snpAddr     = curAddr;
    rspProc     = curProc;
    rspData     = dataReg;
    rspExcl     = curWrite;
  end

  // request latch and transaction scratch state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWrite <= 1'b0;
      curProc  <= '0;
      curAddr  <= '0;
      pending  <= '0;
      dataReg  <= '0;
    end else begin
      if (strobe.accept) begin
        curWrite <= reqWrite;
        curProc  <= reqProc;
        curAddr  <= reqAddr;
      end
      if (strobe.issueSnoop)   pending <= targets;
      else if (strobe.takeAck) pending <= pending & ~ackVec;
      if (strobe.loadMem)       dataReg <= mem[curAddr];
      else if (strobe.takeFill) dataReg <= fillData;
    end
  end

  // directory and backing store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        presence[b] <= '0;
        dirty[b]    <= 1'b0;
        mem[b]      <= MEM_BASE + DATA_W'(b);
      end
    end else begin
      if (strobe.takeFill) mem[curAddr] <= fillData;
      if (strobe.commit) begin
        if (curWrite) begin
          presence[curAddr] <= reqBit;
          dirty[curAddr]    <= 1'b1;
        end else begin
          presence[curAddr] <= presence[curAddr] | reqBit;
          // stays dirty only when the requester already owns it
          dirty[curAddr]    <= isDirty && !haveTargets;
        end
      end
    end
  end

endmodule

// File: rtl/home_directory.sv
module home_directory
  import dir_pkg::*;
#(
  parameter int NUM_PROC   = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 16,
  parameter logic [DATA_W-1:0] MEM_BASE = 'hA000,
  localparam int PROC_W = $clog2(NUM_PROC),
  localparam int ADDR_W = $clog2(NUM_BLOCKS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [PROC_W-1:0]   reqProc,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic                snpValid,
  output logic [1:0]          snpKind,
  output logic [NUM_PROC-1:0] snpTargets,
  output logic [ADDR_W-1:0]   snpAddr,
  input  logic [NUM_PROC-1:0] ackVec,
  input  logic                fillValid,
  input  logic [DATA_W-1:0]   fillData,
  output logic                rspValid,
  output logic [PROC_W-1:0]   rspProc,
  output logic [DATA_W-1:0]   rspData,
  output logic                rspExcl
);

  dirStrobe_t strobe;
  logic isWrite, isDirty, haveTargets, acksDone;

  dir_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fillValid(fillValid),
    .isWrite(isWrite), .isDirty(isDirty), .haveTargets(haveTargets),
    .acksDone(acksDone), .reqReady(reqReady), .strobe(strobe)
  );

  dir_datapath #(
    .NUM_PROC(NUM_PROC), .NUM_BLOCKS(NUM_BLOCKS),
    .DATA_W(DATA_W), .MEM_BASE(MEM_BASE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqProc(reqProc), .reqAddr(reqAddr), .ackVec(ackVec), .fillData(fillData),
    .isWrite(isWrite), .isDirty(isDirty), .haveTargets(haveTargets),
    .acksDone(acksDone), .snpKind(snpKind), .snpTargets(snpTargets),
    .snpAddr(snpAddr), .rspProc(rspProc), .rspData(rspData), .rspExcl(rspExcl)
  );

  assign snpValid = strobe.issueSnoop;
  assign rspValid = strobe.commit;

endmodule

// File: rtl/home_directory_chk.sv
module home_directory_chk #(
  parameter int NUM_PROC = 4,
  localparam int PROC_W  = $clog2(NUM_PROC)
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqReady,
  input logic [PROC_W-1:0]   reqProc,
  input logic                snpValid,
  input logic [1:0]          snpKind,
  input logic [NUM_PROC-1:0] snpTargets,
  input logic                rspValid,
  input logic [PROC_W-1:0]   rspProc
);

  logic [PROC_W-1:0] acceptedProc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acceptedProc <= '0;
    else if (reqValid && reqReady) acceptedProc <= reqProc;
  end

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R9
  idle_after_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);

  // R4
  snoop_has_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpValid |-> (snpTargets != '0));

  // R4
  requester_not_snooped_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpValid |-> (snpTargets[acceptedProc] == 1'b0));

  // R3
  single_owner_recall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpKind != 2'd0) |-> ($countones(snpTargets) == 1));

  // R5
  no_reply_with_snoop_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !snpValid);

  // R2
  reply_to_requester_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspProc == acceptedProc));

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!snpValid && !rspValid));

endmodule

bind home_directory home_directory_chk #(.NUM_PROC(NUM_PROC)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqProc(reqProc), .snpValid(snpValid), .snpKind(snpKind),
  .snpTargets(snpTargets), .rspValid(rspValid), .rspProc(rspProc)
);

// File: tb/home_directory_tb_top.sv
module home_directory_tb_top;

  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [1:0]    reqProc = '0;
  logic [2:0]    reqAddr = '0;
  logic          snpValid;
  logic [1:0]    snpKind;
  logic [NP-1:0] snpTargets;
  logic [2:0]    snpAddr;
  logic [NP-1:0] ackVec = '0;
  logic          fillValid = 1'b0;
  logic [DW-1:0] fillData = '0;
  logic          rspValid;
  logic [1:0]    rspProc;
  logic [DW-1:0] rspData;
  logic          rspExcl;

  int nChecks = 0;
  int nFail = 0;

  // behavioural directory model
  bit [NP-1:0] mPres [NB];
  bit          mDirty[NB];
  int          mMem  [NB];

  always #10 clk = ~clk;

  home_directory #(.NUM_PROC(NP), .NUM_BLOCKS(NB), .DATA_W(DW)) dut_i (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one transaction; busyJunk keeps a conflicting request on the port (R9)
  task automatic transact(input bit w, input int p, input int a, input int ackWait,
                          input bit burst, input int fillVal, input bit busyJunk);
    bit [NP-1:0] bitP;
    bit [NP-1:0] tgt;
    bit [NP-1:0] left;
    bit          expSnoop;
    int          expKind;
    int          expData;
    bit          gotFill;
    bitP     = NP'(1) << p;
    tgt      = mPres[a] & ~bitP;
    expSnoop = mDirty[a] ? (tgt != 0) : (w && tgt != 0);
    expKind  = !mDirty[a] ? 0 : (w ? 2 : 1);
    gotFill  = mDirty[a] && tgt != 0;
    expData  = gotFill ? fillVal : mMem[a];

    @(negedge clk);
    check(reqReady == 1'b1, "R9 ready before request", reqReady, 1);
    reqValid = 1'b1; reqWrite = w; reqProc = 2'(p); reqAddr = 3'(a);
    @(negedge clk);
    if (busyJunk) begin
      reqWrite = 1'b1; reqProc = 2'd3; reqAddr = 3'd0;
    end else reqValid = 1'b0;
    check(reqReady == 1'b0, "R9 busy after accept", reqReady, 0);
    check(snpValid == expSnoop, w ? "R4 snoop presence" : "R2 snoop presence",
          snpValid, expSnoop);
    if (expSnoop) begin
      check(snpTargets == tgt, gotFill ? "R7 snoop targets" : "R4 snoop targets",
            snpTargets, tgt);
      check(snpKind == 2'(expKind), gotFill ? (w ? "R7 kind" : "R3 kind") : "R4 kind",
            snpKind, expKind);
      check(snpAddr == 3'(a), "R4 snoop address", snpAddr, a);
      for (int d = 0; d < ackWait; d++) begin
        @(negedge clk);
        check(rspValid == 1'b0, "R5 reply withheld", rspValid, 0);
        check(reqReady == 1'b0, "R9 busy while waiting", reqReady, 0);
      end
      if (gotFill) begin
        fillValid = 1'b1; fillData = DW'(fillVal);
        @(negedge clk);
        fillValid = 1'b0;
      end else begin
        left = tgt;
        while (left != 0) begin
          if (burst) begin
            ackVec = left; left = '0;
          end else begin
            ackVec = left & (~left + 1'b1);
            left   = left & ~ackVec;
          end
          @(negedge clk);
          ackVec = '0;
          if (left != 0) check(rspValid == 1'b0, "R5 reply before last ack", rspValid, 0);
        end
      end
    end else begin
      @(negedge clk);
    end
    check(rspValid == 1'b1, w ? "R6 reply present" : "R2 reply present", rspValid, 1);
    check(rspData == DW'(expData), gotFill ? (w ? "R7 data" : "R3 data") : "R2 data",
          rspData, expData);
    check(rspExcl == w, "R8 exclusive flag", rspExcl, w);
    check(rspProc == 2'(p), "R2 reply index", rspProc, p);
    reqValid = 1'b0;
    if (gotFill) mMem[a] = fillVal;
    if (w) begin
      mPres[a] = bitP; mDirty[a] = 1'b1;
    end else begin
      mPres[a] = mPres[a] | bitP;
      mDirty[a] = mDirty[a] && !gotFill;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : stim
    for (int b = 0; b < NB; b++) begin
      mPres[b] = '0; mDirty[b] = 1'b0; mMem[b] = 'hA000 + b;
    end
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    check(reqReady == 1'b1, "R1 ready in reset", reqReady, 1);
    check(snpValid == 1'b0, "R1 no snoop in reset", snpValid, 0);
    check(rspValid == 1'b0, "R1 no reply in reset", rspValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);

    transact(0, 0, 3, 0, 0, 0, 0);          // R1/R2 clean read, memory init value
    transact(0, 1, 3, 0, 0, 0, 0);
    transact(0, 2, 3, 0, 0, 0, 0);          // sharers {0,1,2}
    transact(1, 3, 3, 2, 0, 0, 1);          // R4/R5 staggered acks, R9 junk on port
    transact(0, 0, 3, 1, 0, 'h1234, 0);     // R3 downgrade from owner 3
    transact(0, 2, 3, 0, 0, 0, 0);          // R3 now clean, memory updated
    transact(1, 0, 3, 1, 1, 0, 0);          // R4 acks together, targets {2,3}
    transact(1, 1, 3, 3, 0, 'h5678, 1);     // R7 recall-invalidate owner 0
    transact(0, 2, 3, 1, 0, 'h9abc, 0);     // R8 only owner 1 is recalled
    transact(1, 1, 5, 0, 0, 0, 0);          // R6 write without sharers
    transact(0, 2, 5, 1, 0, 'h4321, 0);     // R8 owner 1 recalled on block 5
    transact(0, 2, 0, 0, 0, 0, 0);          // R9 junk write never landed on block 0
    transact(1, 3, 0, 1, 0, 0, 0);          // R4 single sharer invalidated

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule